// File: doc/BRIEF.md
# LCD Clock Source Selector and Divider

This block produces the clock-enable strobe that paces an LCD controller. One 8-bit control register sits at a single bus address. It picks one of three oscillator tick inputs: internal, low-speed or high-speed. It also holds a power-of-two division ratio and an enable bit. The result is a one-cycle strobe, `lcd_tick_o`, in the system clock domain.

The oscillators arrive as single-cycle clock-enable pulses that are synchronous to `clk_i`. The internal and high-speed sources go through a divider, which can divide by 32, 64, 128, 256 or 512. The low-speed source bypasses the divider and is passed through one tick for one strobe.

Reserved codes never produce a strobe. This holds for the reserved source code and for the reserved ratio codes when a divided source is selected. Any write that changes the enable, source or ratio field restarts the divider. Because of this, the first period after a change is always a full period.

Top module: `lcdclk_gen`

## Requirements
- R1: After reset the register reads 0x04, which means ratio field 0, source field 1 (low-speed) and enable 0. `lcd_tick_o` is 0.
- R2: A write stores data bits 6:4 as the ratio, bits 3:2 as the source and bit 0 as the enable. Read data bits 7 and 1 are always 0, whatever was written to them.
- R3: The register is written and read only when `addr_i` equals `REG_ADDR`. A write to any other address leaves the register unchanged, and a read of any other address returns 0x00.
- R4: While the enable bit is 0, `lcd_tick_o` stays 0.
- R5: With source 0 (internal) and ratio code r from 0 to 4, one strobe is issued per 2^(5+r) internal ticks: 32, 64, 128, 256 or 512.
- R6: With source 2 (high-speed), the same ratio rule as R5 applies to the high-speed ticks. Ticks of the sources that are not selected have no effect.
- R7: With source 1 (low-speed), every low-speed tick produces one strobe and the ratio field is ignored.
- R8: Ratio codes 5 to 7 are reserved. With source 0 or 2 selected, a reserved ratio code gives no strobe.
- R9: Source code 3 is reserved and gives no strobe.
- R10: A register write that changes the enable, source or ratio field clears the divider. The next strobe then needs a full 2^(5+r) ticks. A write of the value already held does not disturb the count.
- R11: A strobe is high for exactly one cycle. It appears on the cycle after the tick that completes the period, or after the low-speed tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` (combinational) |
| osc_int_tick_i | input | 1 | Internal oscillator tick |
| osc_low_tick_i | input | 1 | Low-speed oscillator tick |
| osc_high_tick_i | input | 1 | High-speed oscillator tick |
| lcd_tick_o | output | 1 | LCD clock-enable strobe |

## Verification
The assertions take the three oscillator inputs to be single-cycle enables that are already synchronous to `clk_i`. They also take a bus write to be one cycle wide. When a tick arrives in the same cycle as a write that changes the configuration, the assertions give no promise about that tick. The stimulus keeps all tick lines low during every bus write. Between writes it runs all three sources at once with unrelated repeating patterns, so that only the selected source can explain each strobe.

// File: rtl/lcdclk_pkg.sv
package lcdclk_pkg;

  localparam int REG_W     = 8;
  localparam int EN_BIT    = 0;
  localparam int SRC_LSB   = 2;
  localparam int SRC_W     = 2;
  localparam int RATIO_LSB = 4;
  localparam int RATIO_W   = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_INT  = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_HIGH = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    src_e               src;
    logic               en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{ratio: '0, src: SRC_LOW, en: 1'b0};

  function automatic logic [REG_W-1:0] cfg_to_bus(cfg_t c);
    logic [REG_W-1:0] v;
    v = '0;
    v[RATIO_LSB +: RATIO_W] = c.ratio;
    v[SRC_LSB +: SRC_W]     = c.src;
    v[EN_BIT]               = c.en;
    return v;
  endfunction

  function automatic cfg_t bus_to_cfg(logic [REG_W-1:0] v);
    cfg_t c;
    c.ratio = v[RATIO_LSB +: RATIO_W];
    c.src   = src_e'(v[SRC_LSB +: SRC_W]);
    c.en    = v[EN_BIT];
    return c;
  endfunction

endpackage

// File: rtl/lcdclk_regs.sv
module lcdclk_regs
  import lcdclk_pkg::*;
#(
  parameter int               ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output cfg_t              cfg_o,
  output logic              cfg_change_o
);

  cfg_t cfg_q, cfg_new;
  logic hit;

  assign hit          = (addr_i == REG_ADDR);
  assign cfg_new      = bus_to_cfg(wr_data_i);
  assign cfg_change_o = wr_en_i && hit && (cfg_new != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cfg_q <= CFG_RST;
    else if (wr_en_i && hit)   cfg_q <= cfg_new;
  end

  assign cfg_o     = cfg_q;
  assign rd_data_o = hit ? cfg_to_bus(cfg_q) : '0;

  a_r2_rsvd_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7] == 1'b0) && (rd_data_o[1] == 1'b0));

  a_r3_miss_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(cfg_q));

  a_r10_change_moves_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_change_o |=> (cfg_q != $past(cfg_q)));

endmodule

// File: rtl/lcdclk_src_mux.sv
module lcdclk_src_mux
  import lcdclk_pkg::*;
#(
  parameter int NUM_RATIOS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic int_tick_i,
  input  logic low_tick_i,
  input  logic high_tick_i,
  output logic tick_o,
  output logic div_active_o,
  output logic bypass_o
);

  logic ratio_ok;
  assign ratio_ok = (int'(cfg_i.ratio) < NUM_RATIOS);

  always_comb begin
    tick_o       = 1'b0;
    div_active_o = 1'b0;
    bypass_o     = 1'b0;
    if (cfg_i.en) begin
      unique case (cfg_i.src)
        SRC_INT: begin
          tick_o       = int_tick_i;
          div_active_o = ratio_ok;
        end
        SRC_HIGH: begin
          tick_o       = high_tick_i;
          div_active_o = ratio_ok;
        end
        SRC_LOW: begin
          tick_o   = low_tick_i;
          bypass_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  a_r7_path_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({div_active_o, bypass_o}));

  a_r9_rsvd_src_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.src == SRC_RSVD) |-> !(div_active_o || bypass_o));

endmodule

// File: rtl/lcdclk_divider.sv
module lcdclk_divider
  import lcdclk_pkg::*;
#(
  parameter int MIN_LOG2   = 5,
  parameter int NUM_RATIOS = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               active_i,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               term_o
);

  localparam int CNT_W = MIN_LOG2 + NUM_RATIOS - 1;

  logic [CNT_W-1:0]      cnt_q;
  logic [NUM_RATIOS-1:0] at_end;
  logic                  last;

  for (genvar r = 0; r < NUM_RATIOS; r++) begin : g_end
    assign at_end[r] = &cnt_q[MIN_LOG2+r-1:0];
  end

  always_comb begin
    last = 1'b0;
    for (int r = 0; r < NUM_RATIOS; r++)
      if (int'(ratio_i) == r) last = at_end[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || !active_i) cnt_q <= '0;
    else if (tick_i)             cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  assign term_o = active_i && tick_i && last && !clear_i;

  a_r10_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));

  a_r5_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lcdclk_gen.sv
module lcdclk_gen
  import lcdclk_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 4'h3,
  parameter int                MIN_LOG2   = 5,
  parameter int                NUM_RATIOS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  input  logic              osc_int_tick_i,
  input  logic              osc_low_tick_i,
  input  logic              osc_high_tick_i,
  output logic              lcd_tick_o
);

  cfg_t cfg;
  logic cfg_change, sel_tick, div_active, bypass, div_term, tick_q;

  lcdclk_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i, .rd_data_o,
    .cfg_o(cfg), .cfg_change_o(cfg_change)
  );

  lcdclk_src_mux #(.NUM_RATIOS(NUM_RATIOS)) u_mux (
    .clk_i, .rst_ni, .cfg_i(cfg),
    .int_tick_i(osc_int_tick_i), .low_tick_i(osc_low_tick_i),
    .high_tick_i(osc_high_tick_i),
    .tick_o(sel_tick), .div_active_o(div_active), .bypass_o(bypass)
  );

  lcdclk_divider #(.MIN_LOG2(MIN_LOG2), .NUM_RATIOS(NUM_RATIOS)) u_div (
    .clk_i, .rst_ni, .clear_i(cfg_change), .active_i(div_active),
    .tick_i(sel_tick), .ratio_i(cfg.ratio), .term_o(div_term)
  );

  // a config-changing write swallows that cycle's tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= !cfg_change && ((bypass && sel_tick) || div_term);
  end

  assign lcd_tick_o = tick_q;

  a_r4_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.en |=> !lcd_tick_o);

  a_r9_rsvd_src_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.src == SRC_RSVD) |=> !lcd_tick_o);

  a_r8_rsvd_ratio_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg.src != SRC_LOW) && (int'(cfg.ratio) >= NUM_RATIOS)) |=> !lcd_tick_o);

  a_r7_low_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.en && cfg.src == SRC_LOW && osc_low_tick_i && !cfg_change) |=> lcd_tick_o);

  a_r11_no_idle_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_int_tick_i && !osc_low_tick_i && !osc_high_tick_i) |=> !lcd_tick_o);

endmodule

// File: tb/sim_lcdclk_gen.sv
module sim_lcdclk_gen;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h3;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       t_int = 1'b0, t_low = 1'b0, t_high = 1'b0;
  logic       lcd_tick;

  int checks = 0, errors = 0, cyc = 0;
  int exp_cyc[$];
  string exp_tag[$];
  bit done = 1'b0;

  // bench model of the register
  int m_en = 0, m_src = 1, m_ratio = 0, m_cnt = 0;

  always #4 clk = ~clk;

  lcdclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata),
    .osc_int_tick_i(t_int), .osc_low_tick_i(t_low), .osc_high_tick_i(t_high),
    .lcd_tick_o(lcd_tick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic fail(string req, int act, int exp);
    errors++;
    $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
  endtask

  // monitor: pops expected strobes
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        checks++;
        fail({exp_tag[0], " missing strobe"}, 0, 1);
        void'(exp_cyc.pop_front());
        void'(exp_tag.pop_front());
      end
      if (lcd_tick) begin
        checks++;
        if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
          void'(exp_cyc.pop_front());
          void'(exp_tag.pop_front());
        end else begin
          fail("R11 unexpected strobe", 1, 0);
        end
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); #1;
    t_int = 0; t_low = 0; t_high = 0;
    addr = a; wdata = d; wr_en = 1'b1;
    if (a == 4'h3) begin
      if (d[0] != m_en || d[3:2] != m_src || d[6:4] != m_ratio) m_cnt = 0;
      m_en = d[0]; m_src = d[3:2]; m_ratio = d[6:4];
    end
    @(negedge clk); #1;
    wr_en = 1'b0; addr = 4'h3;
  endtask

  task automatic rd_check(logic [3:0] a, logic [7:0] exp, string req);
    @(negedge clk); #1;
    addr = a; #1;
    checks++;
    if (rdata !== exp) fail(req, rdata, exp);
    addr = 4'h3;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      logic ti, tl, th, sel;
      @(negedge clk); #1;
      ti = ((i * 7) % 5) < 3;
      tl = (i % 4) == 0;
      th = ((i * 3) % 7) < 4;
      t_int = ti; t_low = tl; t_high = th;
      sel = (m_src == 0) ? ti : (m_src == 2) ? th : (m_src == 1) ? tl : 1'b0;
      if (m_en == 1 && sel) begin
        if (m_src == 1) begin
          exp_cyc.push_back(cyc + 1); exp_tag.push_back(tag);
        end else if ((m_src == 0 || m_src == 2) && m_ratio <= 4) begin
          m_cnt++;
          if (m_cnt == (32 << m_ratio)) begin
            m_cnt = 0;
            exp_cyc.push_back(cyc + 1); exp_tag.push_back(tag);
          end
        end
      end
    end
    @(negedge clk); #1;
    t_int = 0; t_low = 0; t_high = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fail("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset value and idle output
    rd_check(4'h3, 8'h04, "R1 reset value");
    checks++;
    if (lcd_tick !== 1'b0) fail("R1 output idle", lcd_tick, 0);
    // R2 reserved bits read 0
    wr(4'h3, 8'hFF);
    rd_check(4'h3, 8'h7D, "R2 field storage");
    run(60, "R9 reserved source");
    // R3 address decode
    wr(4'h5, 8'h00);
    rd_check(4'h3, 8'h7D, "R3 miss write ignored");
    rd_check(4'h5, 8'h00, "R3 miss read zero");
    // R5 internal, /32
    wr(4'h3, 8'h01);
    rd_check(4'h3, 8'h01, "R2 readback");
    run(160, "R5 int div32");
    // R5 internal, /512
    wr(4'h3, 8'h41);
    run(1800, "R5 int div512");
    // R6 high, /64
    wr(4'h3, 8'h19);
    run(400, "R6 high div64");
    // R6 high, /256
    wr(4'h3, 8'h39);
    run(900, "R6 high div256");
    // R7 low bypass, ratio ignored
    wr(4'h3, 8'h45);
    run(40, "R7 low bypass");
    wr(4'h3, 8'h75);
    run(40, "R7 low reserved ratio");
    // R8 reserved ratio on divided sources
    wr(4'h3, 8'h59);
    run(200, "R8 reserved ratio high");
    wr(4'h3, 8'h71);
    run(200, "R8 reserved ratio int");
    // R4 disabled
    wr(4'h3, 8'h08);
    run(300, "R4 disabled");
    // R10 same-value write keeps count, change clears
    wr(4'h3, 8'h01);
    run(20, "R10 pre");
    wr(4'h3, 8'h01);
    run(40, "R10 same value");
    wr(4'h3, 8'h11);
    run(150, "R10 after change");
    repeat (4) @(negedge clk);
    checks++;
    if (exp_cyc.size() != 0) fail("R10 pending strobes", exp_cyc.size(), 0);
    finish_run();
  end

endmodule